// File: doc/BRIEF.md
# Contiguous Bit-Run Packer

This block sits between a wide memory reader and a FIFO. Each cycle it may take one wide word with a first-bit index and a last-bit index. Only the bits between the two indices, inclusive, are kept. Each kept run is shifted down and appended directly after the bits already collected, so the output stream is dense. The first kept bit of a stream lands at output bit 0.

Whenever a full output word has been collected, the block writes it to the FIFO in the same cycle as the input that completed it. Leftover bits stay in a residue register for the next word. A line-end marker tells the block whether the last-bit index applies. For words inside a line, the run always extends to the top bit.

A flush request pushes out whatever is held as a zero-padded partial word with a bit count. A full FIFO stalls intake.

Top module: `bit_run_packer`

## Requirements
- R1: After reset the block holds no bits: `out_wr` is 0, and `in_ready` equals the inverse of `fifo_full`.
- R2: An accepted word contributes bits `in_lo` through the effective last index, inclusive. These bits are placed in order directly after the previously packed bits. The first packed bit after reset or after a flush goes to output bit 0.
- R3: In the cycle an accepted word brings the held bit count to W or more, `out_wr` is 1, `out_count` equals W, and `out_data` holds the oldest W bits. The excess bits are kept for later words.
- R4: When `in_last` is 0, `in_hi` is ignored and the effective last index is W-1. When `in_last` is 1, the effective last index is `in_hi`.
- R5: A flush accepted with fewer than W bits held, counting any word accepted in the same cycle, writes a partial word in that cycle. `out_count` equals the held bit count, all `out_data` bits at and above that count are 0, and the block then holds nothing.
- R6: A flush accepted while W or more bits are held writes the full word in that cycle. If bits remain, the next cycle has `in_ready` 0 and writes the remainder as a partial word with its count, provided `fifo_full` is 0.
- R7: While `fifo_full` is 1, `in_ready` is 0 and `out_wr` is 0. A word presented in that cycle is not taken and leaves the held bits unchanged.
- R8: A flush with no bits held and no word accepted writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take a word or a flush this cycle |
| in_data | input | W | Wide input word |
| in_lo | input | log2(W) | Index of the first kept bit |
| in_hi | input | log2(W) | Index of the last kept bit, used when `in_last` is 1 |
| in_last | input | 1 | Word ends a line; `in_hi` applies |
| flush | input | 1 | Emit everything held, padded with zeros |
| fifo_full | input | 1 | Downstream FIFO cannot take a write |
| out_wr | output | 1 | Write strobe to the FIFO |
| out_data | output | W | Packed word |
| out_count | output | log2(W+1) | Number of valid bits in `out_data` |

## Verification
The hardest case to reach is a flush that arrives while the residue and the new run together exceed one word. This case needs a full write, a stalled cycle and a trailing partial write, in that order. The stimulus table builds up a residue of 216 bits and then presents a 200-bit line end together with a flush, followed by an idle slot. In that idle slot the 160-bit remainder must appear. Separate table rows also cover the exact-fit case, where a flush meets exactly W bits and must not produce a second write.

// File: rtl/bit_run_pkg.sv
package bit_run_pkg;

    // Kind of FIFO write produced in a cycle
    typedef enum logic [1:0] {
        WK_NONE  = 2'd0,
        WK_FULL  = 2'd1,
        WK_PART  = 2'd2,
        WK_DRAIN = 2'd3
    } wr_kind_e;

endpackage

// File: rtl/bit_run_extract.sv
module bit_run_extract #(
    parameter int W = 256,
    localparam int IW = $clog2(W),
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  data,
    input  logic [IW-1:0] lo,
    input  logic [IW-1:0] hi,
    input  logic          last,
    output logic [W-1:0]  run,
    output logic [CW-1:0] len
);
    logic [IW-1:0] hi_eff;
    logic [W-1:0]  keep;
    logic [W-1:0]  shifted;

    always_comb begin
        // inside a line the run reaches the top bit
        hi_eff  = last ? hi : IW'(W - 1);
        len     = CW'(hi_eff) - CW'(lo) + CW'(1);
        keep    = ~({W{1'b1}} << len);
        shifted = data >> lo;
        run     = shifted & keep;
    end
endmodule

// File: rtl/bit_run_merge.sv
module bit_run_merge #(
    parameter int W = 256,
    localparam int CW = $clog2(W + 1),
    localparam int RW = 2 * W
) (
    input  logic [RW-1:0] res,
    input  logic [CW-1:0] fill,
    input  logic [W-1:0]  run,
    input  logic [CW-1:0] len,
    input  logic          use_run,
    output logic [RW-1:0] comb,
    output logic [CW:0]   total
);
    logic [RW-1:0] placed;

    always_comb begin
        placed = {{W{1'b0}}, run} << fill;
        if (use_run) begin
            comb  = res | placed;
            total = {1'b0, fill} + {1'b0, len};
        end else begin
            comb  = res;
            total = {1'b0, fill};
        end
    end
endmodule

// File: rtl/bit_run_packer.sv
module bit_run_packer
    import bit_run_pkg::*;
#(
    parameter int W = 256,
    localparam int IW = $clog2(W),
    localparam int CW = $clog2(W + 1),
    localparam int RW = 2 * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [W-1:0]  in_data,
    input  logic [IW-1:0] in_lo,
    input  logic [IW-1:0] in_hi,
    input  logic          in_last,
    input  logic          flush,
    input  logic          fifo_full,
    output logic          out_wr,
    output logic [W-1:0]  out_data,
    output logic [CW-1:0] out_count
);
    typedef struct packed {
        logic [RW-1:0] res;
        logic [CW-1:0] fill;
        logic          pend;
    } state_t;

    state_t   st_q, st_d;
    wr_kind_e kind_d;

    logic [W-1:0]  run;
    logic [CW-1:0] len;
    logic [RW-1:0] comb;
    logic [CW:0]   total;
    logic          accept;
    logic          take_flush;

    bit_run_extract #(.W(W)) i_extract (
        .data (in_data),
        .lo   (in_lo),
        .hi   (in_hi),
        .last (in_last),
        .run  (run),
        .len  (len)
    );

    bit_run_merge #(.W(W)) i_merge (
        .res     (st_q.res),
        .fill    (st_q.fill),
        .run     (run),
        .len     (len),
        .use_run (accept),
        .comb    (comb),
        .total   (total)
    );

    always_comb begin
        st_d       = st_q;
        kind_d     = WK_NONE;
        in_ready   = !fifo_full && !st_q.pend;
        accept     = in_ready && in_valid;
        take_flush = in_ready && flush;

        if (st_q.pend) begin
            if (!fifo_full) begin
                kind_d = WK_DRAIN;
                st_d   = '0;
            end
        end else if (in_ready) begin
            if (total >= (CW+1)'(W)) begin
                kind_d    = WK_FULL;
                st_d.res  = comb >> W;
                st_d.fill = CW'(total - (CW+1)'(W));
                st_d.pend = take_flush && (total != (CW+1)'(W));
            end else if (take_flush && (total != '0)) begin
                kind_d = WK_PART;
                st_d   = '0;
            end else begin
                st_d.res  = comb;
                st_d.fill = total[CW-1:0];
            end
        end

        unique case (kind_d)
            WK_FULL: begin
                out_wr    = 1'b1;
                out_data  = comb[W-1:0];
                out_count = CW'(W);
            end
            WK_PART: begin
                out_wr    = 1'b1;
                out_data  = comb[W-1:0];
                out_count = total[CW-1:0];
            end
            WK_DRAIN: begin
                out_wr    = 1'b1;
                out_data  = st_q.res[W-1:0];
                out_count = st_q.fill;
            end
            default: begin
                out_wr    = 1'b0;
                out_data  = '0;
                out_count = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/bit_run_packer_chk.sv
module bit_run_packer_chk #(
    parameter int W = 256,
    localparam int CW = $clog2(W + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          flush,
    input logic          fifo_full,
    input logic          out_wr,
    input logic [W-1:0]  out_data,
    input logic [CW-1:0] out_count
);
    AST_NO_WR_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !out_wr); // R7

    AST_FULL_STALLS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !in_ready); // R7

    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr |-> (out_count != '0) && (out_count <= CW'(W))); // R5

    AST_PARTIAL_ZERO_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_wr && out_count < CW'(W)) |-> ((out_data >> out_count) == '0)); // R5

    AST_STALL_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !fifo_full) |-> out_wr); // R6

    AST_WR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr |-> ((in_ready && (in_valid || flush)) || !in_ready)); // R3
endmodule

bind bit_run_packer bit_run_packer_chk #(.W(W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .flush     (flush),
    .fifo_full (fifo_full),
    .out_wr    (out_wr),
    .out_data  (out_data),
    .out_count (out_count)
);

// File: tb/test_bit_run_packer.sv
`timescale 1ns/1ps
module test_bit_run_packer;
    localparam int W  = 256;
    localparam int IW = $clog2(W);
    localparam int CW = $clog2(W + 1);
    localparam int NV = 12;

    // row: {valid, lo, hi, last, flush, seed}
    localparam logic [26:0] VEC [NV] = '{
        {1'b1, 8'd100, 8'd0,   1'b0, 1'b0, 8'd1},  // 156 held, R2
        {1'b1, 8'd0,   8'd9,   1'b0, 1'b0, 8'd2},  // hi ignored, 412 -> write, R3 R4
        {1'b1, 8'd0,   8'd50,  1'b1, 1'b0, 8'd3},  // 51 bits, 207
        {1'b1, 8'd10,  8'd200, 1'b0, 1'b0, 8'd4},  // hi ignored -> 246 bits, R4
        {1'b1, 8'd255, 8'd255, 1'b1, 1'b0, 8'd5},  // single top bit
        {1'b1, 8'd0,   8'd57,  1'b1, 1'b1, 8'd6},  // exact fit with flush
        {1'b1, 8'd3,   8'd3,   1'b1, 1'b1, 8'd7},  // one-bit partial, R5
        {1'b1, 8'd0,   8'd0,   1'b0, 1'b1, 8'd8},  // full word, nothing left
        {1'b1, 8'd40,  8'd0,   1'b0, 1'b0, 8'd9},  // 216 held
        {1'b1, 8'd0,   8'd199, 1'b1, 1'b1, 8'd10}, // full + pending, R6
        {1'b0, 8'd0,   8'd0,   1'b0, 1'b0, 8'd11}, // drain slot, R6
        {1'b0, 8'd0,   8'd0,   1'b0, 1'b1, 8'd12}  // empty flush, R8
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [W-1:0]  in_data = '0;
    logic [IW-1:0] in_lo = '0;
    logic [IW-1:0] in_hi = '0;
    logic          in_last = 1'b0;
    logic          flush = 1'b0;
    logic          fifo_full = 1'b0;
    logic          out_wr;
    logic [W-1:0]  out_data;
    logic [CW-1:0] out_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model of held bits
    logic [2*W-1:0] m_res = '0;
    int             m_cnt = 0;
    bit             m_pend = 1'b0;

    always #2.5 clk = ~clk;

    bit_run_packer #(.W(W)) i_bit_run_packer (.*);

    function automatic logic [W-1:0] gen(input int seed);
        logic [W-1:0] r;
        for (int k = 0; k < W/32; k++)
            r[k*32 +: 32] = (32'(seed) + 32'd1) * 32'h9E3779B1 ^ (32'(k) * 32'h01010101);
        return r;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit v, input logic [W-1:0] d, input int lo, input int hi,
                        input bit last, input bit fl, input bit full);
        logic [2*W-1:0] t;
        int             c;
        bit             e_rdy, e_wr, n_pend;
        logic [W-1:0]   e_data;
        int             e_cnt;
        string          tag;
        @(negedge clk);
        in_valid = v; in_data = d; in_lo = IW'(lo); in_hi = IW'(hi);
        in_last = last; flush = fl; fifo_full = full;
        #1;
        e_rdy = !full && !m_pend;
        e_wr = 1'b0; e_data = '0; e_cnt = 0; n_pend = 1'b0;
        t = m_res; c = m_cnt; tag = "R2";
        if (full) begin
            tag = "R7";
        end else if (m_pend) begin
            tag = "R6"; e_wr = 1'b1; e_data = t[W-1:0]; e_cnt = c; t = '0; c = 0;
        end else begin
            if (v) begin
                int top = last ? hi : W - 1;
                for (int i = lo; i <= top; i++) begin
                    t[c] = d[i];
                    c++;
                end
            end
            if (c >= W) begin
                tag = fl ? "R6" : "R3";
                e_wr = 1'b1; e_data = t[W-1:0]; e_cnt = W;
                t = t >> W; c -= W;
                n_pend = fl && (c > 0);
            end else if (fl && c > 0) begin
                tag = "R5"; e_wr = 1'b1; e_data = t[W-1:0]; e_cnt = c; t = '0; c = 0;
            end else if (fl) begin
                tag = "R8";
            end
        end
        check(tag, "in_ready", W'(in_ready), W'(e_rdy));
        check(tag, "out_wr", W'(out_wr), W'(e_wr));
        if (e_wr && out_wr) begin
            check(tag, "out_data", out_data, e_data);
            check(tag, "out_count", W'(out_count), W'(e_cnt));
        end
        @(posedge clk);
        if (!full) begin
            m_res = t; m_cnt = c; m_pend = n_pend;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; flush = 1'b0; fifo_full = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_res = '0; m_cnt = 0; m_pend = 1'b0;
        #1;
        check("R1", "in_ready after reset", W'(in_ready), W'(1));
        check("R1", "out_wr after reset", W'(out_wr), W'(0));
    endtask

    initial begin
        do_reset();
        for (int n = 0; n < NV; n++) begin
            logic [26:0] r = VEC[n];
            step(r[26], gen(int'(r[7:0])), int'(r[25:18]), int'(r[17:10]),
                 r[9], r[8], 1'b0);
        end
        // R7: a word offered while full is dropped; held bits stay at 56
        step(1'b1, gen(20), 200, 0, 1'b0, 1'b0, 1'b0);
        step(1'b1, gen(21), 0, 0, 1'b0, 1'b1, 1'b1);
        step(1'b0, '0, 0, 0, 1'b0, 1'b1, 1'b0);
        // R4: hi honoured at line end
        step(1'b1, {W{1'b1}}, 5, 9, 1'b1, 1'b1, 1'b0);
        // R1: reset mid-stream discards held bits
        step(1'b1, gen(22), 0, 29, 1'b1, 1'b0, 1'b0);
        do_reset();
        step(1'b0, '0, 0, 0, 1'b0, 1'b1, 1'b0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule